// File: doc/BRIEF.md
# Tearing-Effect Sync Trigger Detector

A display panel can report its refresh position on one tearing-effect wire, with both line and frame sync pulses on it. This block watches that wire and tells the two kinds of pulse apart by how long each one lasts. A frame pulse, which is the long one, clears a line counter. A line pulse, which is the short one, advances it. When the counter reaches a programmed line, the block issues a one-clock start trigger, so that a frame write can begin without tearing.

Settings are loaded as one word through a single write strobe, and each write is checked as it arrives. An illegal combination leaves the previous settings in force and raises an error flag. A legal write clears that flag and starts the frame tracking afresh. Besides the two waiting modes, there is a mode with no wait at all: it fires the trigger once, directly from the write.

Top module: `tear_sync_trigger`

## Requirements
- R1: A write with a line pulse width below 2 ticks is rejected. `cfg_err` goes high on the next clock and the earlier settings stay in force.
- R2: A write is rejected when the frame pulse width is below the minimum for its mode. The minimum is 4 ticks in mode 1 and 2 ticks in modes 0 and 2.
- R3: A write whose frame pulse width equals its line pulse width is rejected.
- R4: A write is rejected when the line number is above 2047 or when the mode code is 3.
- R5: After reset, `trig` and `cfg_err` are low and the block is disabled. An accepted write clears `cfg_err`, loads every setting and restarts frame tracking.
- R6: A pulse that has lasted at least the frame width when it ends counts as a frame sync and clears the line count. A pulse that has lasted at least the line width but less than the frame width counts as a line sync and adds one to the count. A shorter pulse is ignored. The level of `te_in` is sampled on each clock.
- R7: In modes 1 and 2, `trig` is high for one clock, on the clock after the end of the line pulse that brings the count to the programmed line. A line number of 0 in mode 1 waits for the first line pulse. The trigger fires at most once per frame.
- R8: In mode 2 with line number 0, the frame sync alone fires the trigger, on the clock after that pulse ends.
- R9: Mode 0 ignores `te_in`. An accepted write with enable set fires exactly one trigger, on the next clock.
- R10: A polarity input of 1 makes high the active level of that pulse kind. A value of 0 makes low the active level.
- R11: While disabled, the block never triggers. Line pulses seen before the first frame sync after a write are not counted.
- R12: A pulse that ends in the same cycle as a write, accepted or not, is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the settings word |
| cfg_enable | input | 1 | Enable setting |
| cfg_mode | input | 2 | Mode: 0 no wait, 1 and 2 wait on the tearing signal, 3 illegal |
| cfg_hs_pol | input | 1 | Line pulse polarity, 1 for active high |
| cfg_vs_pol | input | 1 | Frame pulse polarity, 1 for active high |
| cfg_hs_width | input | TW | Minimum line pulse width, in clocks |
| cfg_vs_width | input | TW | Minimum frame pulse width, in clocks |
| cfg_line | input | LINE_IN_W | Line number at which to trigger |
| te_in | input | 1 | Tearing-effect input from the panel |
| trig | output | 1 | One-clock start-transfer pulse |
| cfg_err | output | 1 | The last write was rejected |

## Verification
Two events can fall in the same cycle. The first is the end of a pulse together with a settings write. The bench provokes it by releasing a qualifying line pulse on the very edge that carries the write, then checks that no trigger appears and that a later frame is still needed. The second is a single long pulse that meets both width thresholds at once. The bench checks that this pulse acts only as a frame sync, by counting which line pulse afterwards raises the trigger. In both cases a behavioural model running alongside the design gives the expected value of `trig` and `cfg_err` on every clock.

// File: rtl/tear_sync_trigger.sv
module tear_sync_trigger #(
  parameter int TW        = 6,
  parameter int LW        = 11,
  parameter int LINE_IN_W = 16,
  parameter int CNT_W     = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic                 cfg_enable,
  input  logic [1:0]           cfg_mode,
  input  logic                 cfg_hs_pol,
  input  logic                 cfg_vs_pol,
  input  logic [TW-1:0]        cfg_hs_width,
  input  logic [TW-1:0]        cfg_vs_width,
  input  logic [LINE_IN_W-1:0] cfg_line,
  input  logic                 te_in,
  output logic                 trig,
  output logic                 cfg_err
);
  localparam logic [TW-1:0]        RUN_MAX  = {TW{1'b1}};
  localparam logic [CNT_W-1:0]     CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [LINE_IN_W-1:0] LINE_MAX = LINE_IN_W'((2 ** LW) - 1);

  logic            en_q, hpol_q, vpol_q, seen_q, fired_q;
  logic [1:0]      mode_q;
  logic [TW-1:0]   hs_w_q, vs_w_q, hrun_q, vrun_q;
  logic [LW-1:0]   line_q;
  logic [CNT_W-1:0] lcnt_q;

  logic [TW-1:0] vs_min;
  logic          bad_wr;
  assign vs_min = (cfg_mode == 2'd1) ? TW'(4) : TW'(2);
  assign bad_wr = (cfg_mode == 2'd3) || (cfg_line > LINE_MAX) ||
                  (cfg_hs_width < TW'(2)) || (cfg_vs_width < vs_min) ||
                  (cfg_hs_width == cfg_vs_width);

  logic h_act, v_act, v_evt, h_evt;
  assign h_act = (te_in == hpol_q);
  assign v_act = (te_in == vpol_q);
  assign v_evt = !v_act && (vrun_q >= vs_w_q);
  assign h_evt = !h_act && (hrun_q >= hs_w_q) && !v_evt;

  logic [CNT_W-1:0] lcnt_inc, target;
  assign lcnt_inc = (lcnt_q == CNT_MAX) ? lcnt_q : lcnt_q + 1'b1;
  assign target   = (line_q == '0) ? CNT_W'(1) : CNT_W'(line_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hrun_q <= '0;
      vrun_q <= '0;
    end else begin
      hrun_q <= h_act ? ((hrun_q == RUN_MAX) ? hrun_q : hrun_q + 1'b1) : '0;
      vrun_q <= v_act ? ((vrun_q == RUN_MAX) ? vrun_q : vrun_q + 1'b1) : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      mode_q  <= 2'd0;
      hpol_q  <= 1'b1;
      vpol_q  <= 1'b1;
      hs_w_q  <= TW'(2);
      vs_w_q  <= TW'(4);
      line_q  <= '0;
      cfg_err <= 1'b0;
      seen_q  <= 1'b0;
      fired_q <= 1'b0;
      lcnt_q  <= '0;
      trig    <= 1'b0;
    end else begin
      trig <= 1'b0;
      if (cfg_we) begin
        cfg_err <= bad_wr;
        if (!bad_wr) begin
          en_q    <= cfg_enable;
          mode_q  <= cfg_mode;
          hpol_q  <= cfg_hs_pol;
          vpol_q  <= cfg_vs_pol;
          hs_w_q  <= cfg_hs_width;
          vs_w_q  <= cfg_vs_width;
          line_q  <= LW'(cfg_line);
          seen_q  <= 1'b0;
          fired_q <= 1'b0;
          lcnt_q  <= '0;
          trig    <= cfg_enable && (cfg_mode == 2'd0);
        end
      end else if (en_q && mode_q != 2'd0) begin
        if (v_evt) begin
          seen_q <= 1'b1;
          lcnt_q <= '0;
          if (mode_q == 2'd2 && line_q == '0) begin
            trig    <= 1'b1;
            fired_q <= 1'b1;
          end else begin
            fired_q <= 1'b0;
          end
        end else if (h_evt && seen_q) begin
          lcnt_q <= lcnt_inc;
          if (lcnt_inc == target && !fired_q) begin
            trig    <= 1'b1;
            fired_q <= 1'b1;
          end
        end
      end
    end
  end

  assert_trig_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> !trig);
  assert_trig_needs_enable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> en_q);
  assert_hs_floor_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_hs_width < TW'(2)) |=> (cfg_err && $stable(hs_w_q)));
  assert_equal_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_hs_width == cfg_vs_width) |=> cfg_err);
  assert_line_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_line > LINE_MAX) |=> (cfg_err && $stable(line_q)));
  assert_mode1_vs_floor_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_mode == 2'd1 && cfg_vs_width < TW'(4)) |=> cfg_err);
  assert_write_drops_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !(cfg_enable && cfg_mode == 2'd0)) |=> !trig);
endmodule

// File: tb/tb_tear_sync_trigger.sv
`timescale 1ns/1ps
module tb_tear_sync_trigger;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_enable = 1'b0, cfg_hs_pol = 1'b1, cfg_vs_pol = 1'b1;
  logic [1:0] cfg_mode = 2'd0;
  logic [5:0] cfg_hs_width = 6'd2, cfg_vs_width = 6'd4;
  logic [15:0] cfg_line = 16'd0;
  logic te_in = 1'b0;
  logic trig, cfg_err;

  always #2 clk = ~clk;

  tear_sync_trigger dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_enable(cfg_enable),
    .cfg_mode(cfg_mode), .cfg_hs_pol(cfg_hs_pol), .cfg_vs_pol(cfg_vs_pol),
    .cfg_hs_width(cfg_hs_width), .cfg_vs_width(cfg_vs_width),
    .cfg_line(cfg_line), .te_in(te_in), .trig(trig), .cfg_err(cfg_err));

  int checks = 0, errors = 0, ntrig = 0, cycles = 0;
  string cur_req = "R5";

  // behavioural reference
  int m_hs = 2, m_vs = 4, m_line = 0, m_mode = 0, hrun = 0, vrun = 0, cnt = 0;
  bit m_en = 0, m_hp = 1, m_vp = 1, seen = 0, fired = 0, m_trig = 0, m_err = 0;

  always @(posedge clk) begin
    bit nt, ha, va, ve, he, bad;
    int vmin, tgt;
    if (!rst_n) begin
      m_hs = 2; m_vs = 4; m_line = 0; m_mode = 0; hrun = 0; vrun = 0; cnt = 0;
      m_en = 0; m_hp = 1; m_vp = 1; seen = 0; fired = 0; m_trig = 0; m_err = 0;
    end else begin
      nt = 0;
      ha = (te_in == m_hp);
      va = (te_in == m_vp);
      ve = !va && vrun >= m_vs;
      he = !ha && hrun >= m_hs && !ve;
      hrun = ha ? ((hrun < 63) ? hrun + 1 : 63) : 0;
      vrun = va ? ((vrun < 63) ? vrun + 1 : 63) : 0;
      if (cfg_we) begin
        vmin = (cfg_mode == 1) ? 4 : 2;
        bad = (cfg_mode == 3) || (cfg_line > 2047) || (cfg_hs_width < 2) ||
              (cfg_vs_width < vmin) || (cfg_hs_width == cfg_vs_width);
        m_err = bad;
        if (!bad) begin
          m_en = cfg_enable; m_mode = cfg_mode; m_hp = cfg_hs_pol; m_vp = cfg_vs_pol;
          m_hs = cfg_hs_width; m_vs = cfg_vs_width; m_line = cfg_line;
          seen = 0; fired = 0; cnt = 0;
          nt = cfg_enable && cfg_mode == 0;
        end
      end else if (m_en && m_mode != 0) begin
        if (ve) begin
          seen = 1; cnt = 0; fired = 0;
          if (m_mode == 2 && m_line == 0) begin nt = 1; fired = 1; end
        end else if (he && seen) begin
          cnt = (cnt < 4095) ? cnt + 1 : 4095;
          tgt = (m_line == 0) ? 1 : m_line;
          if (cnt == tgt && !fired) begin nt = 1; fired = 1; end
        end
      end
      m_trig = nt;
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk(trig == m_trig, {cur_req, " trig vs model"}, trig, m_trig);
      chk(cfg_err == m_err, {cur_req, " err vs model"}, cfg_err, m_err);
      if (trig) ntrig++;
    end
    if (cycles > 100000) begin
      chk(0, "watchdog", cycles, 100000);
      summary();
    end
  end

  task automatic cfg(input bit en, input int mode, input bit hp, input bit vp,
                     input int hs, input int vs, input int line);
    @(negedge clk);
    cfg_enable = en; cfg_mode = 2'(mode); cfg_hs_pol = hp; cfg_vs_pol = vp;
    cfg_hs_width = 6'(hs); cfg_vs_width = 6'(vs); cfg_line = 16'(line); cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse(input bit lvl, input int len);
    te_in = lvl;
    repeat (len) @(negedge clk);
    te_in = ~lvl;
    repeat (3) @(negedge clk);
  endtask

  task automatic frame(input bit lvl, input int vlen, input int hlen, input int nh);
    pulse(lvl, vlen);
    for (int i = 0; i < nh; i++) pulse(lvl, hlen);
  endtask

  int base;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(trig == 0 && cfg_err == 0, "R5 reset state", {trig, cfg_err}, 0);

    cur_req = "R1";
    cfg(1, 1, 1, 1, 1, 6, 3);
    chk(cfg_err == 1, "R1 hs width 1 rejected", cfg_err, 1);

    cur_req = "R5";
    cfg(1, 1, 1, 1, 3, 6, 3);
    chk(cfg_err == 0, "R5 legal write clears error", cfg_err, 0);

    cur_req = "R7";
    base = ntrig;
    te_in = 0; pulse(1, 7); pulse(1, 2);
    for (int i = 0; i < 5; i++) pulse(1, 4);
    chk(ntrig - base == 1, "R7 one trigger on third line, short pulse ignored (R6)", ntrig - base, 1);

    cur_req = "R2";
    cfg(1, 1, 1, 1, 2, 3, 1);
    chk(cfg_err == 1, "R2 mode1 vs width 3 rejected", cfg_err, 1);
    base = ntrig;
    frame(1, 7, 4, 4);
    chk(ntrig - base == 1, "R1 rejected write keeps old settings", ntrig - base, 1);
    cfg(1, 2, 1, 1, 2, 3, 1);
    chk(cfg_err == 0, "R2 mode2 vs width 3 accepted", cfg_err, 0);

    cur_req = "R3";
    cfg(1, 1, 1, 1, 5, 5, 1);
    chk(cfg_err == 1, "R3 equal widths rejected", cfg_err, 1);

    cur_req = "R4";
    cfg(1, 1, 1, 1, 3, 6, 2048);
    chk(cfg_err == 1, "R4 line 2048 rejected", cfg_err, 1);
    cfg(1, 3, 1, 1, 3, 6, 1);
    chk(cfg_err == 1, "R4 mode 3 rejected", cfg_err, 1);
    cfg(1, 1, 1, 1, 3, 6, 2047);
    chk(cfg_err == 0, "R4 line 2047 accepted", cfg_err, 0);

    cur_req = "R6";
    cfg(1, 1, 1, 1, 3, 6, 2);
    base = ntrig;
    pulse(1, 9); pulse(1, 4); pulse(1, 8); pulse(1, 4); pulse(1, 4);
    chk(ntrig - base == 1, "R6 long pulse restarts count, not a line", ntrig - base, 1);

    cur_req = "R7";
    cfg(1, 1, 1, 1, 3, 6, 0);
    base = ntrig;
    frame(1, 6, 3, 3);
    chk(ntrig - base == 1, "R7 mode1 line 0 fires on first line", ntrig - base, 1);

    cur_req = "R11";
    cfg(1, 1, 1, 1, 3, 6, 1);
    base = ntrig;
    for (int i = 0; i < 3; i++) pulse(1, 4);
    chk(ntrig - base == 0, "R11 lines before frame sync not counted", ntrig - base, 0);

    cur_req = "R8";
    cfg(1, 2, 1, 1, 2, 5, 0);
    base = ntrig;
    frame(1, 6, 3, 3);
    chk(ntrig - base == 1, "R8 mode2 line 0 fires on frame sync only", ntrig - base, 1);

    cur_req = "R9";
    base = ntrig;
    cfg(1, 0, 1, 1, 3, 6, 5);
    frame(1, 8, 4, 6);
    chk(ntrig - base == 1, "R9 mode0 fires once from write", ntrig - base, 1);

    cur_req = "R10";
    te_in = 1;
    cfg(1, 1, 0, 0, 3, 6, 2);
    base = ntrig;
    frame(0, 7, 4, 3);
    chk(ntrig - base == 1, "R10 active-low pulses decoded", ntrig - base, 1);
    te_in = 0;

    cur_req = "R11";
    cfg(0, 1, 1, 1, 3, 6, 1);
    base = ntrig;
    frame(1, 7, 4, 3);
    chk(ntrig - base == 0, "R11 disabled never triggers", ntrig - base, 0);

    cur_req = "R12";
    cfg(1, 1, 1, 1, 3, 6, 1);
    pulse(1, 7);
    base = ntrig;
    te_in = 1;
    repeat (4) @(negedge clk);
    te_in = 0; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    repeat (3) @(negedge clk);
    pulse(1, 4);
    chk(ntrig - base == 0, "R12 pulse ending with write dropped", ntrig - base, 0);
    frame(1, 7, 4, 1);
    chk(ntrig - base == 1, "R12 next frame triggers normally", ntrig - base, 1);

    repeat (4) @(negedge clk);
    summary();
  end
endmodule